// File: doc/BRIEF.md
# PLL Lock-Loss Clock Fallback Controller

This block is the control logic that sits beside a set of glitch-free clock multiplexers and an on-chip PLL. It drives the select lines of four aligned-clock multiplexers and the standby-clock multiplexer. It also drives the PLL reference-source select, the PLL bypass control and the enable of the memory-controller clock gate. Each of these outputs comes from one of two sources. In normal mode it follows a run-time configuration register. While a single override bit is set, it takes a fixed safe selection instead.

Software sets the override bit when it sees that the PLL has lost lock. That 0-to-1 change latches a pending interrupt for a supervising controller. The block then watches the PLL lock indication, which passes through a two-flop synchronizer. Once lock has been seen for a programmable number of consecutive cycles, the block clears the override by itself, and the PLL clock becomes the main source again. The override bit resets to 1, so the chip starts on the safe clocks.

Top module: `clkfb_ctrl`

## Requirements
- R1: After reset the override bit is 1 and the interrupt is 0. The qualify count is 4 and every run-time field is 0, so CFG (address 0) reads 0x0100_0400. The outputs show the safe selection.
- R2: When the override bit is 0, each output equals its CFG field one clock edge after the write. The fields are: aligned-mux selects in bits [3:0] (1 = PLL clock), standby select in bit 4, reference select in bit 5, bypass in bit 6 and memory clock enable in bit 7.
- R3: When the override bit is 1, all four aligned-mux selects are 0 (standby clock). The standby select is 0 (RC oscillator).
- R4: When the override bit is 1, the reference select is 1 (fabric base clock), the bypass control is 0 and the memory clock enable is 0, whatever the CFG fields hold.
- R5: A CFG write that takes override bit 24 from 0 to 1 sets the pending interrupt, and irq is high after that write edge. Writing 1 when the bit is already 1 does not set it.
- R6: Writing STAT (address 1) with bit 0 = 1 clears the pending interrupt. Writing bit 0 = 0 leaves it unchanged.
- R7: While the override bit is 1, it is cleared once the synchronized lock has been high for N consecutive cycles. N is CFG bits [15:8], and 0 counts as 1. Any low cycle of the synchronized lock restarts the count.
- R8: The lock input reaches STAT bit 1 after two clock edges.
- R9: CFG bits [31:28] are reserved, and bits [27:25] and [23:16] are not implemented. All of them read 0 and ignore writes.
- R10: All outputs are registered. A change of the override bit reaches every output on the same edge, one edge after the bit changes.
- R11: In normal mode a set bypass field drives the PLL bypass control high. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 CFG, 1 STAT |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 CFG, 1 STAT |
| rd_data | output | 32 | Combinational read data |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| irq | output | 1 | Pending interrupt to the supervising controller |
| amux_sel | output | 4 | Aligned-clock mux selects, 1 = PLL clock |
| stby_sel | output | 1 | Standby mux select, 0 = RC oscillator |
| ref_sel | output | 1 | PLL reference select, 0 = RC oscillator, 1 = fabric base clock |
| pll_bypass | output | 1 | PLL bypass control |
| memclk_en | output | 1 | Memory-controller clock gate enable |

## Verification
Register contents and irq are due at the write edge itself. The bench reads them at the following falling edge. The select outputs lag the registers by one more edge, so each task first checks that the old value still holds there, then checks the new value one edge later. For an automatic clear with count N, the bench raises lock at a falling edge. It then expects the override still set after N+1 edges and cleared after N+2, because two edges go to the synchronizer. A count of 0 uses the window for N = 1.

// File: rtl/clkfb_pkg.sv
package clkfb_pkg;

    localparam int DATA_W  = 32;
    localparam int AMUX_N  = 4;
    localparam int QUAL_W  = 8;

    // CFG field positions
    localparam int F_AMUX  = 0;
    localparam int F_STBY  = F_AMUX + AMUX_N;
    localparam int F_REF   = F_STBY + 1;
    localparam int F_BYP   = F_REF + 1;
    localparam int F_MEMEN = F_BYP + 1;
    localparam int F_QUAL  = F_MEMEN + 1;
    localparam int F_OVR   = 24;

    // STAT field positions
    localparam int S_PEND  = 0;
    localparam int S_LOCK  = 1;

    localparam logic [QUAL_W-1:0] QUAL_RST = QUAL_W'(4);

    typedef enum logic {
        ADDR_CFG  = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic [QUAL_W-1:0] qual;
        logic              memen;
        logic              byp;
        logic              refs;
        logic              stby;
        logic [AMUX_N-1:0] amux;
    } cfg_t;

    typedef struct packed {
        logic [AMUX_N-1:0] amux;
        logic              stby;
        logic              refs;
        logic              byp;
        logic              memen;
    } sel_t;

    function automatic sel_t safe_sel();
        sel_t s;
        s.amux  = '0;
        s.stby  = 1'b0;
        s.refs  = 1'b1;
        s.byp   = 1'b0;
        s.memen = 1'b0;
        return s;
    endfunction

    function automatic sel_t run_sel(cfg_t c);
        sel_t s;
        s.amux  = c.amux;
        s.stby  = c.stby;
        s.refs  = c.refs;
        s.byp   = c.byp;
        s.memen = c.memen;
        return s;
    endfunction

    function automatic cfg_t cfg_from_word(logic [DATA_W-1:0] w);
        cfg_t c;
        c.amux  = w[F_AMUX +: AMUX_N];
        c.stby  = w[F_STBY];
        c.refs  = w[F_REF];
        c.byp   = w[F_BYP];
        c.memen = w[F_MEMEN];
        c.qual  = w[F_QUAL +: QUAL_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(cfg_t c, logic ovr);
        logic [DATA_W-1:0] w;
        w = '0;
        w[F_AMUX +: AMUX_N] = c.amux;
        w[F_STBY]           = c.stby;
        w[F_REF]            = c.refs;
        w[F_BYP]            = c.byp;
        w[F_MEMEN]          = c.memen;
        w[F_QUAL +: QUAL_W] = c.qual;
        w[F_OVR]            = ovr;
        return w;
    endfunction

endpackage

// File: rtl/clkfb_sync.sv
module clkfb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkfb_regs.sv
module clkfb_regs
    import clkfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hw_clr,
    input  logic              lock_s,
    output cfg_t              cfg_q,
    output logic              ovr_q,
    output logic              pend_q,
    output logic              cfg_wr,
    output logic              stat_clr
);
    logic ovr_d, pend_d, pend_set;

    assign cfg_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_CFG);
    assign stat_clr = wr_en && (reg_addr_e'(wr_addr) == ADDR_STAT) && wr_data[S_PEND];
    assign pend_set = cfg_wr && wr_data[F_OVR] && !ovr_q;

    always_comb begin
        ovr_d = ovr_q;
        if (cfg_wr)      ovr_d = wr_data[F_OVR];
        else if (hw_clr) ovr_d = 1'b0;

        pend_d = pend_q;
        if (pend_set)      pend_d = 1'b1;
        else if (stat_clr) pend_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            cfg_q.qual <= QUAL_RST;
            ovr_q      <= 1'b1;
            pend_q     <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_from_word(wr_data);
            ovr_q  <= ovr_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_addr_e'(rd_addr) == ADDR_CFG) begin
            rd_data = cfg_to_word(cfg_q, ovr_q);
        end else begin
            rd_data[S_PEND] = pend_q;
            rd_data[S_LOCK] = lock_s;
        end
    end
endmodule

// File: rtl/clkfb_lockq.sv
module clkfb_lockq
    import clkfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ovr,
    input  logic              lock_s,
    input  logic [QUAL_W-1:0] qual,
    output logic              hw_clr
);
    logic [QUAL_W-1:0] cnt_q;
    logic [QUAL_W-1:0] last;

    assign last   = (qual == '0) ? '0 : qual - 1'b1;
    assign hw_clr = ovr && lock_s && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (!ovr || !lock_s)  cnt_q <= '0;
        else if (hw_clr)           cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/clkfb_outsel.sv
module clkfb_outsel
    import clkfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ovr,
    input  cfg_t              cfg,
    output logic [AMUX_N-1:0] amux_sel,
    output logic              stby_sel,
    output logic              ref_sel,
    output logic              pll_bypass,
    output logic              memclk_en
);
    sel_t nxt, rst_val;

    assign rst_val = safe_sel();
    assign nxt     = ovr ? safe_sel() : run_sel(cfg);

    for (genvar i = 0; i < AMUX_N; i++) begin : g_amux
        always_ff @(posedge clk) begin
            if (rst) amux_sel[i] <= rst_val.amux[i];
            else     amux_sel[i] <= nxt.amux[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stby_sel   <= rst_val.stby;
            ref_sel    <= rst_val.refs;
            pll_bypass <= rst_val.byp;
            memclk_en  <= rst_val.memen;
        end else begin
            stby_sel   <= nxt.stby;
            ref_sel    <= nxt.refs;
            pll_bypass <= nxt.byp;
            memclk_en  <= nxt.memen;
        end
    end
endmodule

// File: rtl/clkfb_ctrl.sv
module clkfb_ctrl
    import clkfb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pll_lock,
    output logic              irq,
    output logic [AMUX_N-1:0] amux_sel,
    output logic              stby_sel,
    output logic              ref_sel,
    output logic              pll_bypass,
    output logic              memclk_en
);
    cfg_t cfg_q;
    logic ovr_q, pend_q, lock_s, hw_clr, cfg_wr, stat_clr;

    clkfb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pll_lock),
        .q   (lock_s)
    );

    clkfb_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hw_clr   (hw_clr),
        .lock_s   (lock_s),
        .cfg_q    (cfg_q),
        .ovr_q    (ovr_q),
        .pend_q   (pend_q),
        .cfg_wr   (cfg_wr),
        .stat_clr (stat_clr)
    );

    clkfb_lockq u_lockq (
        .clk    (clk),
        .rst    (rst),
        .ovr    (ovr_q),
        .lock_s (lock_s),
        .qual   (cfg_q.qual),
        .hw_clr (hw_clr)
    );

    clkfb_outsel u_out (
        .clk        (clk),
        .rst        (rst),
        .ovr        (ovr_q),
        .cfg        (cfg_q),
        .amux_sel   (amux_sel),
        .stby_sel   (stby_sel),
        .ref_sel    (ref_sel),
        .pll_bypass (pll_bypass),
        .memclk_en  (memclk_en)
    );

    assign irq = pend_q;
endmodule

// File: rtl/clkfb_ctrl_chk.sv
module clkfb_ctrl_chk
    import clkfb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ovr_q,
    input logic              lock_s,
    input logic              cfg_wr,
    input logic              stat_clr,
    input cfg_t              cfg_q,
    input logic              irq,
    input logic [AMUX_N-1:0] amux_sel,
    input logic              stby_sel,
    input logic              ref_sel,
    input logic              pll_bypass,
    input logic              memclk_en
);
    assert_safe_amux_R3: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> (amux_sel == '0) && !stby_sel);

    assert_safe_ctl_R4: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ref_sel && !pll_bypass && !memclk_en);

    assert_run_follow_R2: assert property (@(posedge clk) disable iff (rst)
        !ovr_q |=> (amux_sel == $past(cfg_q.amux)) && (ref_sel == $past(cfg_q.refs)));

    assert_run_bypass_R11: assert property (@(posedge clk) disable iff (rst)
        !ovr_q |=> pll_bypass == $past(cfg_q.byp));

    assert_irq_on_set_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> irq);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_clr) |=> irq);

    assert_clear_needs_lock_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr_q) |-> ($past(lock_s) || $past(cfg_wr)));
endmodule

bind clkfb_ctrl clkfb_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ovr_q      (ovr_q),
    .lock_s     (lock_s),
    .cfg_wr     (cfg_wr),
    .stat_clr   (stat_clr),
    .cfg_q      (cfg_q),
    .irq        (irq),
    .amux_sel   (amux_sel),
    .stby_sel   (stby_sel),
    .ref_sel    (ref_sel),
    .pll_bypass (pll_bypass),
    .memclk_en  (memclk_en)
);

// File: tb/sim_clkfb_ctrl.sv
module sim_clkfb_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        pll_lock = 1'b0;
    logic        irq;
    logic [3:0]  amux_sel;
    logic        stby_sel, ref_sel, pll_bypass, memclk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] SAFE = 8'h04;

    always #5 clk = ~clk;

    clkfb_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pll_lock(pll_lock), .irq(irq),
        .amux_sel(amux_sel), .stby_sel(stby_sel), .ref_sel(ref_sel),
        .pll_bypass(pll_bypass), .memclk_en(memclk_en)
    );

    function automatic logic [7:0] obs();
        return {amux_sel, stby_sel, ref_sel, pll_bypass, memclk_en};
    endfunction

    task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ovr_bit(output logic b);
        logic [31:0] d;
        rd(1'b0, d);
        b = d[24];
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(1'b0, d);
        expect_eq("R1 cfg", d, 32'h0100_0400);
        expect_eq("R1 irq", {31'b0, irq}, 32'h0);
        expect_eq("R1 outputs", {24'b0, obs()}, {24'b0, SAFE});
        expect_eq("R11 bypass reset", {31'b0, pll_bypass}, 32'h0);
    endtask

    task automatic t_normal();
        wr(1'b0, 32'h0000_04DA);
        expect_eq("R10 held until next edge", {24'b0, obs()}, {24'b0, SAFE});
        @(negedge clk);
        expect_eq("R2 pattern A", {24'b0, obs()}, 32'h0000_00AB);
        expect_eq("R11 bypass follows", {31'b0, pll_bypass}, 32'h1);
        wr(1'b0, 32'h0000_0425);
        @(negedge clk);
        expect_eq("R2 pattern B", {24'b0, obs()}, 32'h0000_0054);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        pll_lock = 1'b1;
        @(negedge clk);
        rd(1'b1, d);
        expect_eq("R8 one edge", {31'b0, d[1]}, 32'h0);
        @(negedge clk);
        rd(1'b1, d);
        expect_eq("R8 two edges", {31'b0, d[1]}, 32'h1);
        pll_lock = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_override();
        wr(1'b0, 32'h0100_04DA);
        expect_eq("R5 irq on set", {31'b0, irq}, 32'h1);
        expect_eq("R10 old outputs", {24'b0, obs()}, 32'h0000_0054);
        @(negedge clk);
        expect_eq("R3 R4 forced safe", {24'b0, obs()}, {24'b0, SAFE});
        wr(1'b1, 32'h0);
        expect_eq("R6 write 0 keeps irq", {31'b0, irq}, 32'h1);
        wr(1'b1, 32'h1);
        expect_eq("R6 w1c clears irq", {31'b0, irq}, 32'h0);
        wr(1'b0, 32'h0100_04DA);
        expect_eq("R5 no irq when already set", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_autoclear(logic [7:0] n, logic [7:0] eff);
        logic b;
        wr(1'b0, {8'h01, 8'h00, n, 8'hDA});
        wr(1'b1, 32'h1);
        pll_lock = 1'b1;
        repeat (eff + 1) @(negedge clk);
        ovr_bit(b);
        expect_eq("R7 still overridden", {31'b0, b}, 32'h1);
        @(negedge clk);
        ovr_bit(b);
        expect_eq("R7 cleared on lock", {31'b0, b}, 32'h0);
        expect_eq("R10 safe until next edge", {24'b0, obs()}, {24'b0, SAFE});
        @(negedge clk);
        expect_eq("R2 back to run values", {24'b0, obs()}, 32'h0000_00AB);
        pll_lock = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_restart();
        logic b;
        wr(1'b0, 32'h0100_04DA);
        wr(1'b1, 32'h1);
        pll_lock = 1'b1;
        repeat (3) @(negedge clk);
        pll_lock = 1'b0;
        repeat (3) @(negedge clk);
        pll_lock = 1'b1;
        repeat (5) @(negedge clk);
        ovr_bit(b);
        expect_eq("R7 count restarted", {31'b0, b}, 32'h1);
        @(negedge clk);
        ovr_bit(b);
        expect_eq("R7 cleared after full run", {31'b0, b}, 32'h0);
        pll_lock = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(1'b0, 32'hF000_04DA);
        rd(1'b0, d);
        expect_eq("R9 reserved ignored", d, 32'h0000_04DA);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d);
        expect_eq("R9 unimplemented read zero", d, 32'h0100_FFFF);
        wr(1'b1, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_normal();
        t_sync();
        t_override();
        t_autoclear(8'd3, 8'd3);
        t_autoclear(8'd0, 8'd1);
        t_restart();
        t_reserved();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule